// File: doc/BRIEF.md
# Multi-Core Halt Power-State Controller

This block follows the run and halt status of every core in a small multi-core processor and sequences the package between its power states. These are: running, clock-stopped, and a deep halt in which the core clock ratio and then the supply voltage are lowered. Each core halts on its own halt strobe and the other cores keep running. Broadcast wake events bring halted cores back. A system-management interrupt moves every core into a management mode. When that mode ends, a resume-target input sends the cores either back to running or back to halt.

The deep halt is entered only when every core is halted and the deep-halt enable is set. Entry lowers the clock ratio first, through a level request/acknowledge pair, and then lowers the voltage through a second pair. Exit undoes these steps in reverse order. The request lines are levels, and the controller waits until each acknowledge matches its request. A wake that arrives while the clock is stopped or while a ratio or voltage step is in progress is latched. It is applied in the first cycle the package is running again. All outputs are registered and change at the clock edge that samples the stimulus. The external bus clock is not touched; only the core ratio request moves.

Top module: `halt_pm_ctrl`

## Requirements
- R1: A halt strobe on core i clears core_run_en[i] after the next edge; the enables of the other cores stay high.
- R2: Any of wake_bus_init, wake_soft_init, wake_nmi, wake_intr or wake_bus_irq, seen while the package is running (pkg_state 0), returns every halted core to running after the next edge.
- R3: wake_smi puts every running or halted core into management mode, where its enable is high and halt strobes are ignored. wake_smi takes priority over the other wakes in the same cycle. rsm_stb then sends each such core to halt if rsm_to_halt is 1, or to running if it is 0.
- R4: stop_clk_req in pkg_state 0 moves the package to clock-stop (pkg_state 1). There all enables are low and halt strobes are ignored. On release the package returns to pkg_state 0 with every core in the same run/halt state it had before.
- R5: The package leaves pkg_state 0 for ratio entry (pkg_state 2) only when every core is halted, deep_en is 1 and no wake is present.
- R6: ratio_low_req rises in pkg_state 2. volt_low_req rises only after ratio_ack is seen (pkg_state 3). The deep halt (pkg_state 4) follows volt_ack.
- R7: A wake in pkg_state 4 drops volt_low_req first (pkg_state 5) and waits for volt_ack to fall. It then drops ratio_low_req (pkg_state 6) and waits for ratio_ack to fall before pkg_state 0. Core enables stay low throughout.
- R8: No ratio or voltage step advances while its acknowledge does not yet match its request level.
- R9: A wake seen outside pkg_state 0 is held and applied in the first pkg_state 0 cycle. A wake seen during pkg_state 2 sends the package to pkg_state 6 once ratio_ack arrives, skipping the voltage step.
- R10: snoop_ok is high in pkg_state 0 and 4 and low in all other states.
- R11: A synchronous rst overrides every input. It gives all enables high, pkg_state 0, both requests low and snoop_ok high after the edge, and it clears any held wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_stb | input | NCORES | Per-core halt instruction strobe |
| wake_smi | input | 1 | System-management interrupt |
| wake_bus_init | input | 1 | Bus-error initialization event |
| wake_soft_init | input | 1 | Initialization request |
| wake_nmi | input | 1 | Non-maskable interrupt line |
| wake_intr | input | 1 | Maskable interrupt line |
| wake_bus_irq | input | 1 | Interrupt message delivered over the system bus |
| rsm_stb | input | 1 | Leave management mode |
| rsm_to_halt | input | 1 | Resume target: 1 halt, 0 running |
| stop_clk_req | input | 1 | Stop-clock request (level) |
| deep_en | input | 1 | Deep halt enable |
| ratio_ack | input | 1 | Ratio logic acknowledge, follows ratio_low_req |
| volt_ack | input | 1 | Voltage logic acknowledge, follows volt_low_req |
| core_run_en | output | NCORES | Per-core run enable |
| ratio_low_req | output | 1 | Request for the low core clock ratio |
| volt_low_req | output | 1 | Request for the low voltage code |
| snoop_ok | output | 1 | Bus snoops may be serviced |
| pkg_state | output | 3 | Package state: 0 run, 1 clock-stop, 2 ratio down, 3 voltage down, 4 deep, 5 voltage up, 6 ratio up |

## Verification
Every output is due exactly one edge after the stimulus it answers. The bench applies inputs on a falling edge and lets one rising edge pass. It compares all outputs on the following falling edge, before the next stimulus. Effects that take two steps, such as a wake held through clock-stop or a ratio step, are checked as one row per edge: the cycle where the package is back in state 0 with cores still halted comes first, then the cycle where the held wake releases the cores. Acknowledge lines are held at the wrong level for extra rows to show that the state does not move.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic [1:0] {
    C_RUN  = 2'd0,
    C_HALT = 2'd1,
    C_SMM  = 2'd2
  } core_st_e;

  typedef enum logic [2:0] {
    P_RUN       = 3'd0,
    P_CLKSTOP   = 3'd1,
    P_RATIO_DN  = 3'd2,
    P_VOLT_DN   = 3'd3,
    P_DEEP      = 3'd4,
    P_VOLT_UP   = 3'd5,
    P_RATIO_UP  = 3'd6
  } pkg_st_e;

  localparam int WAKE_W   = 6;
  localparam int WAKE_SMI = 0;
endpackage

// File: rtl/hpc_core_tracker.sv
module hpc_core_tracker
  import hpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     live,
  input  logic     halt_stb,
  input  logic     smi_go,
  input  logic     int_go,
  input  logic     rsm_stb,
  input  logic     rsm_to_halt,
  output core_st_e st_q,
  output core_st_e st_d
);
  always_comb begin
    st_d = st_q;
    if (live) begin
      case (st_q)
        C_RUN:  if (smi_go) st_d = C_SMM;
                else if (halt_stb) st_d = C_HALT;
        C_HALT: if (smi_go) st_d = C_SMM;
                else if (int_go) st_d = C_RUN;
        C_SMM:  if (rsm_stb) st_d = rsm_to_halt ? C_HALT : C_RUN;
        default: st_d = C_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= C_RUN;
    else     st_q <= st_d;
  end

  // R4: a core's state is frozen while the package is not running
  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !live |=> $stable(st_q));

  // R3: management mode ignores halt strobes until resume
  p_smm_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == C_SMM && live && !rsm_stb) |=> st_q == C_SMM);
endmodule

// File: rtl/hpc_wake_latch.sv
module hpc_wake_latch
  import hpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              live,
  input  logic [WAKE_W-1:0] wake,
  output logic              smi_eff,
  output logic              int_eff
);
  logic pend_smi_q, pend_int_q;
  logic smi_now, int_now;

  assign smi_now = wake[WAKE_SMI];
  assign int_now = |wake[WAKE_W-1:1];
  assign smi_eff = smi_now | pend_smi_q;
  assign int_eff = int_now | pend_int_q;

  always_ff @(posedge clk) begin
    if (rst || live) begin
      pend_smi_q <= 1'b0;
      pend_int_q <= 1'b0;
    end else begin
      pend_smi_q <= pend_smi_q | smi_now;
      pend_int_q <= pend_int_q | int_now;
    end
  end

  // R9: a held wake survives until the package runs again
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!live && pend_int_q) |=> pend_int_q);

  // R9: a running cycle consumes every held wake
  p_pend_clear_r9: assert property (@(posedge clk) disable iff (rst)
    live |=> (!pend_int_q && !pend_smi_q));
endmodule

// File: rtl/hpc_pkg_fsm.sv
module hpc_pkg_fsm
  import hpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stop_req,
  input  logic    deep_en,
  input  logic    all_halted,
  input  logic    wake_eff,
  input  logic    ratio_ack,
  input  logic    volt_ack,
  output pkg_st_e st_q,
  output pkg_st_e st_d
);
  always_comb begin
    st_d = st_q;
    case (st_q)
      P_RUN:      if (stop_req) st_d = P_CLKSTOP;
                  else if (all_halted && deep_en && !wake_eff) st_d = P_RATIO_DN;
      P_CLKSTOP:  if (!stop_req) st_d = P_RUN;
      P_RATIO_DN: if (ratio_ack) st_d = wake_eff ? P_RATIO_UP : P_VOLT_DN;
      P_VOLT_DN:  if (volt_ack) st_d = P_DEEP;
      P_DEEP:     if (wake_eff) st_d = P_VOLT_UP;
      P_VOLT_UP:  if (!volt_ack) st_d = P_RATIO_UP;
      P_RATIO_UP: if (!ratio_ack) st_d = P_RUN;
      default:    st_d = P_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= P_RUN;
    else     st_q <= st_d;
  end

  // R5: deep entry only with every core halted and the enable set
  p_deep_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_RATIO_DN && $past(st_q) == P_RUN) |-> $past(all_halted && deep_en));

  // R6: the voltage step starts only after the ratio acknowledge
  p_ratio_first_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_VOLT_DN && $past(st_q) == P_RATIO_DN) |-> $past(ratio_ack));

  // R8: no advance while the acknowledge is still missing
  p_wait_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_RATIO_DN && !ratio_ack) |=> st_q == P_RATIO_DN);

  // R7: the ratio is restored only after the voltage
  p_exit_order_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_RATIO_UP) |-> ($past(st_q) == P_VOLT_UP || $past(st_q) == P_RATIO_UP
                              || $past(st_q) == P_RATIO_DN));

  // R4: releasing stop-clock returns to the running state
  p_clkstop_back_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_CLKSTOP && !stop_req) |=> st_q == P_RUN);
endmodule

// File: rtl/halt_pm_ctrl.sv
module halt_pm_ctrl
  import hpc_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCORES-1:0] halt_stb,
  input  logic              wake_smi,
  input  logic              wake_bus_init,
  input  logic              wake_soft_init,
  input  logic              wake_nmi,
  input  logic              wake_intr,
  input  logic              wake_bus_irq,
  input  logic              rsm_stb,
  input  logic              rsm_to_halt,
  input  logic              stop_clk_req,
  input  logic              deep_en,
  input  logic              ratio_ack,
  input  logic              volt_ack,
  output logic [NCORES-1:0] core_run_en,
  output logic              ratio_low_req,
  output logic              volt_low_req,
  output logic              snoop_ok,
  output logic [2:0]        pkg_state
);
  logic [WAKE_W-1:0] wake_vec;
  logic              smi_eff, int_eff, live;
  logic [NCORES-1:0] halted_vec;
  logic [NCORES-1:0] run_d;
  pkg_st_e           pst_q, pst_d;

  assign wake_vec = {wake_bus_irq, wake_intr, wake_nmi, wake_soft_init,
                     wake_bus_init, wake_smi};
  assign live = (pst_q == P_RUN);

  hpc_wake_latch u_wake (
    .clk(clk), .rst(rst), .live(live), .wake(wake_vec),
    .smi_eff(smi_eff), .int_eff(int_eff)
  );

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    core_st_e cst_q, cst_d;
    hpc_core_tracker u_trk (
      .clk(clk), .rst(rst), .live(live), .halt_stb(halt_stb[i]),
      .smi_go(smi_eff), .int_go(int_eff), .rsm_stb(rsm_stb),
      .rsm_to_halt(rsm_to_halt), .st_q(cst_q), .st_d(cst_d)
    );
    assign halted_vec[i] = (cst_q == C_HALT);
    assign run_d[i]      = (cst_d != C_HALT) && (pst_d == P_RUN);
  end

  hpc_pkg_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(stop_clk_req), .deep_en(deep_en),
    .all_halted(&halted_vec), .wake_eff(smi_eff | int_eff),
    .ratio_ack(ratio_ack), .volt_ack(volt_ack), .st_q(pst_q), .st_d(pst_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_run_en   <= '1;
      ratio_low_req <= 1'b0;
      volt_low_req  <= 1'b0;
      snoop_ok      <= 1'b1;
      pkg_state     <= 3'd0;
    end else begin
      core_run_en   <= run_d;
      ratio_low_req <= (pst_d == P_RATIO_DN) || (pst_d == P_VOLT_DN) ||
                       (pst_d == P_DEEP) || (pst_d == P_VOLT_UP);
      volt_low_req  <= (pst_d == P_VOLT_DN) || (pst_d == P_DEEP);
      snoop_ok      <= (pst_d == P_RUN) || (pst_d == P_DEEP);
      pkg_state     <= pst_d;
    end
  end

  // R6: the low voltage is never requested without the low ratio
  p_volt_needs_ratio_r6: assert property (@(posedge clk) disable iff (rst)
    volt_low_req |-> ratio_low_req);

  // R7: cores stay gated while any request is still active
  p_gated_during_steps_r7: assert property (@(posedge clk) disable iff (rst)
    ratio_low_req |-> (core_run_en == '0));
endmodule

// File: tb/tb_halt_pm_ctrl.sv
`timescale 1ns/1ps
module tb_halt_pm_ctrl;
  localparam int NC = 4;
  localparam int NV = 42;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0] halt_stb = '0;
  logic wake_smi = 0, wake_bus_init = 0, wake_soft_init = 0;
  logic wake_nmi = 0, wake_intr = 0, wake_bus_irq = 0;
  logic rsm_stb = 0, rsm_to_halt = 0, stop_clk_req = 0, deep_en = 0;
  logic ratio_ack = 0, volt_ack = 0;
  logic [NC-1:0] core_run_en;
  logic ratio_low_req, volt_low_req, snoop_ok;
  logic [2:0] pkg_state;
  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  halt_pm_ctrl #(.NCORES(NC)) dut (
    .clk(clk), .rst(rst), .halt_stb(halt_stb), .wake_smi(wake_smi),
    .wake_bus_init(wake_bus_init), .wake_soft_init(wake_soft_init),
    .wake_nmi(wake_nmi), .wake_intr(wake_intr), .wake_bus_irq(wake_bus_irq),
    .rsm_stb(rsm_stb), .rsm_to_halt(rsm_to_halt), .stop_clk_req(stop_clk_req),
    .deep_en(deep_en), .ratio_ack(ratio_ack), .volt_ack(volt_ack),
    .core_run_en(core_run_en), .ratio_low_req(ratio_low_req),
    .volt_low_req(volt_low_req), .snoop_ok(snoop_ok), .pkg_state(pkg_state)
  );

  // row: {req, halt[4], wake{smi,businit,init,nmi,intr,busirq}, ctl{stop,en,rsm,rth,rack,vack},
  //       exp run[4], exp state[3], exp {ratio_req, volt_req, snoop}}
  localparam logic [29:0] VEC [NV] = '{
    {4'd1, 4'b0001, 6'b000000, 6'b000000, 4'b1110, 3'd0, 3'b001}, // R1 one core halts
    {4'd1, 4'b0000, 6'b000000, 6'b000000, 4'b1110, 3'd0, 3'b001}, // R1 others keep running
    {4'd5, 4'b1110, 6'b000000, 6'b000000, 4'b0000, 3'd0, 3'b001}, // R5 all halted, enable low
    {4'd5, 4'b0000, 6'b000000, 6'b000000, 4'b0000, 3'd0, 3'b001}, // R5 no deep entry
    {4'd2, 4'b0000, 6'b000100, 6'b000000, 4'b1111, 3'd0, 3'b001}, // R2 nmi wakes all
    {4'd1, 4'b1111, 6'b000000, 6'b000000, 4'b0000, 3'd0, 3'b001}, // R1 all halt
    {4'd4, 4'b0000, 6'b000000, 6'b100000, 4'b0000, 3'd1, 3'b000}, // R4 clock-stop
    {4'd4, 4'b0000, 6'b000000, 6'b100000, 4'b0000, 3'd1, 3'b000}, // R4 hold
    {4'd4, 4'b0000, 6'b000000, 6'b000000, 4'b0000, 3'd0, 3'b001}, // R4 back to halt
    {4'd4, 4'b0000, 6'b000000, 6'b000000, 4'b0000, 3'd0, 3'b001}, // R4 still halted
    {4'd4, 4'b0000, 6'b000000, 6'b100000, 4'b0000, 3'd1, 3'b000}, // R4 clock-stop again
    {4'd9, 4'b0000, 6'b000001, 6'b100000, 4'b0000, 3'd1, 3'b000}, // R9 bus irq held
    {4'd9, 4'b0000, 6'b000000, 6'b000000, 4'b0000, 3'd0, 3'b001}, // R9 run, not yet applied
    {4'd9, 4'b0000, 6'b000000, 6'b000000, 4'b1111, 3'd0, 3'b001}, // R9 held wake applied
    {4'd5, 4'b1111, 6'b000000, 6'b010000, 4'b0000, 3'd0, 3'b001}, // R5 halt with enable
    {4'd5, 4'b0000, 6'b000000, 6'b010000, 4'b0000, 3'd2, 3'b100}, // R5 ratio entry
    {4'd8, 4'b0000, 6'b000000, 6'b010000, 4'b0000, 3'd2, 3'b100}, // R8 wait ratio ack
    {4'd6, 4'b0000, 6'b000000, 6'b010010, 4'b0000, 3'd3, 3'b110}, // R6 then voltage
    {4'd8, 4'b0000, 6'b000000, 6'b010010, 4'b0000, 3'd3, 3'b110}, // R8 wait volt ack
    {4'd6, 4'b0000, 6'b000000, 6'b010011, 4'b0000, 3'd4, 3'b111}, // R6 deep reached
    {4'd10,4'b0000, 6'b000000, 6'b010011, 4'b0000, 3'd4, 3'b111}, // R10 snoop in deep
    {4'd7, 4'b0000, 6'b001000, 6'b010011, 4'b0000, 3'd5, 3'b100}, // R7 voltage up first
    {4'd8, 4'b0000, 6'b000000, 6'b010011, 4'b0000, 3'd5, 3'b100}, // R8 wait volt ack low
    {4'd7, 4'b0000, 6'b000000, 6'b010010, 4'b0000, 3'd6, 3'b000}, // R7 ratio up
    {4'd8, 4'b0000, 6'b000000, 6'b010010, 4'b0000, 3'd6, 3'b000}, // R8 wait ratio ack low
    {4'd7, 4'b0000, 6'b000000, 6'b010000, 4'b0000, 3'd0, 3'b001}, // R7 running, cores gated
    {4'd9, 4'b0000, 6'b000000, 6'b010000, 4'b1111, 3'd0, 3'b001}, // R9 held wake releases
    {4'd3, 4'b0000, 6'b100000, 6'b000000, 4'b1111, 3'd0, 3'b001}, // R3 smi to mgmt mode
    {4'd3, 4'b1111, 6'b000000, 6'b000000, 4'b1111, 3'd0, 3'b001}, // R3 halt ignored
    {4'd3, 4'b0000, 6'b000000, 6'b001100, 4'b0000, 3'd0, 3'b001}, // R3 resume to halt
    {4'd3, 4'b0000, 6'b100000, 6'b000000, 4'b1111, 3'd0, 3'b001}, // R3 smi from halt
    {4'd3, 4'b0000, 6'b000000, 6'b001000, 4'b1111, 3'd0, 3'b001}, // R3 resume to run
    {4'd5, 4'b1111, 6'b000000, 6'b010000, 4'b0000, 3'd0, 3'b001}, // R5 halt all
    {4'd5, 4'b0000, 6'b000000, 6'b010000, 4'b0000, 3'd2, 3'b100}, // R5 ratio entry
    {4'd9, 4'b0000, 6'b000010, 6'b010000, 4'b0000, 3'd2, 3'b100}, // R9 wake mid-step
    {4'd9, 4'b0000, 6'b000000, 6'b010010, 4'b0000, 3'd6, 3'b000}, // R9 skip voltage
    {4'd8, 4'b0000, 6'b000000, 6'b010010, 4'b0000, 3'd6, 3'b000}, // R8 wait ratio ack low
    {4'd7, 4'b0000, 6'b000000, 6'b010000, 4'b0000, 3'd0, 3'b001}, // R7 back to run
    {4'd9, 4'b0000, 6'b000000, 6'b000000, 4'b1111, 3'd0, 3'b001}, // R9 wake applied
    {4'd4, 4'b0000, 6'b000000, 6'b100000, 4'b0000, 3'd1, 3'b000}, // R4 stop running cores
    {4'd4, 4'b1111, 6'b000000, 6'b100000, 4'b0000, 3'd1, 3'b000}, // R4 halt ignored
    {4'd4, 4'b0000, 6'b000000, 6'b000000, 4'b1111, 3'd0, 3'b001}  // R4 cores still run
  };

  task automatic drive(input logic [15:0] v);
    {halt_stb, wake_smi, wake_bus_init, wake_soft_init, wake_nmi, wake_intr,
     wake_bus_irq, stop_clk_req, deep_en, rsm_stb, rsm_to_halt,
     ratio_ack, volt_ack} = v;
  endtask

  task automatic step(input logic [15:0] v);
    drive(v);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic [9:0] exp, input string what);
    logic [9:0] act;
    act = {core_run_en, pkg_state, ratio_low_req, volt_low_req, snoop_ok};
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin : main
    drive('0);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(11, 10'b1111_000_001, "R11 reset state");

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][25:10]);
      check(int'(VEC[k][29:26]), VEC[k][9:0], $sformatf("row %0d", k));
    end

    // R3 priority: smi and init together on halted cores go to mgmt mode
    step({4'b1111, 6'b000000, 6'b000000});
    check(1, 10'b0000_000_001, "R1 halt before priority test");
    step({4'b0000, 6'b101000, 6'b000000});
    check(3, 10'b1111_000_001, "R3 smi with init");
    step({4'b1111, 6'b000000, 6'b000000});
    check(3, 10'b1111_000_001, "R3 halt ignored after smi priority");
    step({4'b0000, 6'b000000, 6'b001000});
    check(3, 10'b1111_000_001, "R3 resume to run");

    // R11 reset from deep halt
    step({4'b1111, 6'b000000, 6'b010000});
    step({4'b0000, 6'b000000, 6'b010000});
    step({4'b0000, 6'b000000, 6'b010010});
    step({4'b0000, 6'b000000, 6'b010011});
    check(6, 10'b0000_100_111, "R6 deep before reset");
    rst = 1'b1;
    step({4'b0000, 6'b001000, 6'b010011});
    check(11, 10'b1111_000_001, "R11 reset overrides deep");
    rst = 1'b0;
    step({4'b0000, 6'b000000, 6'b000000});
    check(11, 10'b1111_000_001, "R11 no held wake after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule